// File: doc/BRIEF.md
# Two-cycle ternary bit-manipulation unit

This unit is a 32-bit execution block for six bit-manipulation operations: conditional mix, conditional move, funnel shift left and right, and rotate left and right. Each operation takes two cycles. The datapath has two operands, so a three-source operation is split into halves. In the first cycle the unit computes a partial value from rs1 and rs2 and saves it in a stage register. In the second cycle it switches its first operand from rs1 to rs3 and merges that operand with the saved value. One 63-bit shifter and one bitwise-logic path are shared by both halves.

The pipeline pulses `start_i` with the operation and operands. When the unit accepts an operation it raises `busy_o` for the following cycle. During that cycle the pipeline stalls and holds the operands steady. The next cycle brings a one-cycle `done_o` pulse together with the new `result_o`. A new operation may be started in that same done cycle.

Top module: `ternary_bitmanip_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: A start is accepted when `start_i` is high and `busy_o` is low. `busy_o` is then high for exactly the next cycle, and the operands must stay unchanged during that cycle. `done_o` is high for exactly the cycle after that.
- R3: A `start_i` raised while `busy_o` is high is ignored. The running operation finishes on time and no second completion follows.
- R4: `result_o` changes only in a cycle where `done_o` is high, and otherwise keeps the last completed value.
- R5: Conditional move (`op_i`=1) returns rs1 when rs2 is nonzero, and rs3 when rs2 is zero.
- R6: Conditional mix (`op_i`=0) returns (rs1 AND rs2) OR (rs3 AND NOT rs2).
- R7: Rotate left (`op_i`=4) and rotate right (`op_i`=5) rotate rs1 by rs2 modulo 32. An amount of 0 returns rs1.
- R8: Funnel shift right (`op_i`=3) returns the low 32 bits of the 64-bit value {rs3, rs1} rotated right by rs2 modulo 64.
- R9: Funnel shift left (`op_i`=2) returns the high 32 bits of the 64-bit value {rs1, rs3} rotated left by rs2 modulo 64.
- R10: For either funnel shift, an amount (rs2 modulo 64) of 0 returns rs1 and an amount of 32 returns rs3.
- R11: Operation codes 6 and 7 follow the same two-cycle timing and complete with a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new operation |
| op_i | input | 3 | Operation select |
| rs1_i | input | 32 | First source operand |
| rs2_i | input | 32 | Second source operand (selector or amount) |
| rs3_i | input | 32 | Third source operand |
| busy_o | output | 1 | High during the second cycle; the pipeline stalls |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Registered result of the last completed operation |

## Verification
Two events can share a cycle: one operation completing and the next being accepted. A start can also arrive during the busy cycle, and the unit must drop it. The bench issues many operations back to back, so each new start lands in the previous operation's done cycle. It also raises `start_i` with a different operation code during busy cycles. A behavioural model decides each cycle which starts were taken. The bench then compares busy, done and result against that model every cycle, which catches a lost completion, an extra one, or a result from the wrong operation.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam logic [2:0] OP_CMIX = 3'd0;
  localparam logic [2:0] OP_CMOV = 3'd1;
  localparam logic [2:0] OP_FSL  = 3'd2;
  localparam logic [2:0] OP_FSR  = 3'd3;
  localparam logic [2:0] OP_ROL  = 3'd4;
  localparam logic [2:0] OP_ROR  = 3'd5;

  // operations whose second half reads the third source
  function automatic logic uses_rs3(input logic [2:0] op);
    return (op == OP_CMIX) || (op == OP_CMOV) || (op == OP_FSL) || (op == OP_FSR);
  endfunction
endpackage

// File: rtl/tbm_seq.sv
module tbm_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [2:0] op_i,
  output logic       accept_o,
  output logic       phase2_o,
  output logic       done_o,
  output logic [2:0] op_cur_o,
  output logic [2:0] op_held_o
);
  logic       phase2_q;
  logic       done_q;
  logic [2:0] op_q;

  assign accept_o = start_i && !phase2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase2_q <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= '0;
    end else begin
      done_q   <= phase2_q;
      phase2_q <= accept_o;
      if (accept_o) op_q <= op_i;
    end
  end

  assign phase2_o  = phase2_q;
  assign done_o    = done_q;
  assign op_cur_o  = phase2_q ? op_q : op_i;
  assign op_held_o = op_q;
endmodule

// File: rtl/tbm_operand_mux.sv
module tbm_operand_mux #(
  parameter int W = 32
) (
  input  logic [W-1:0] rs1_i,
  input  logic [W-1:0] rs2_i,
  input  logic [W-1:0] rs3_i,
  input  logic         sel_rs3_i,
  output logic [W-1:0] opa_o,
  output logic [W-1:0] opb_o
);
  assign opa_o = sel_rs3_i ? rs3_i : rs1_i;
  assign opb_o = rs2_i;
endmodule

// File: rtl/tbm_shifter.sv
module tbm_shifter #(
  parameter int W = 32,
  localparam int AW = $clog2(W),
  localparam int SW = 2 * W - 1
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  input  logic          left_i,
  input  logic          fill_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0]  fwd;
  logic [W-1:0]  shr;
  logic [SW-1:0] wide;

  // left shifts reuse the right shifter through bit reversal
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign fwd[i] = left_i ? data_i[W-1-i] : data_i[i];
  end

  assign wide = {{(W-1){fill_i}}, fwd};
  assign shr  = W'(wide >> amt_i);

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign data_o[i] = left_i ? shr[W-1-i] : shr[i];
  end
endmodule

// File: rtl/tbm_bwlogic.sv
module tbm_bwlogic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         invert_b_i,
  output logic [W-1:0] y_o
);
  assign y_o = a_i & (invert_b_i ? ~b_i : b_i);
endmodule

// File: rtl/ternary_bitmanip_unit.sv
module ternary_bitmanip_unit #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] rs1_i,
  input  logic [W-1:0] rs2_i,
  input  logic [W-1:0] rs3_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  import tbm_pkg::*;

  logic          accept, phase2;
  logic [2:0]    op_cur, op_held;
  logic [W-1:0]  opa, opb;
  logic [AW-1:0] amt_lo, amt_cmpl, sh_amt;
  logic          amt_hi, sh_left;
  logic [W-1:0]  sh_out, bw_out;
  logic [W-1:0]  stage_q, stage_d, merged;
  logic [W-1:0]  result_q;

  tbm_seq seq_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .op_i      (op_i),
    .accept_o  (accept),
    .phase2_o  (phase2),
    .done_o    (done_o),
    .op_cur_o  (op_cur),
    .op_held_o (op_held)
  );

  tbm_operand_mux #(.W(W)) mux_i (
    .rs1_i     (rs1_i),
    .rs2_i     (rs2_i),
    .rs3_i     (rs3_i),
    .sel_rs3_i (phase2 && uses_rs3(op_held)),
    .opa_o     (opa),
    .opb_o     (opb)
  );

  assign amt_lo   = opb[AW-1:0];
  assign amt_hi   = opb[AW];
  assign amt_cmpl = '0 - amt_lo;

  // direction and amount for the shared shifter, per operation and half
  always_comb begin
    sh_left = 1'b0;
    sh_amt  = '0;
    unique case (op_cur)
      OP_ROR: begin
        sh_left = phase2;
        sh_amt  = phase2 ? amt_cmpl : amt_lo;
      end
      OP_ROL: begin
        sh_left = !phase2;
        sh_amt  = phase2 ? amt_cmpl : amt_lo;
      end
      OP_FSR: begin
        sh_left = amt_hi ? !phase2 : phase2;
        if (amt_hi) sh_amt = phase2 ? amt_lo : amt_cmpl;
        else        sh_amt = phase2 ? amt_cmpl : amt_lo;
      end
      OP_FSL: begin
        sh_left = amt_hi ? phase2 : !phase2;
        if (amt_hi) sh_amt = phase2 ? amt_lo : amt_cmpl;
        else        sh_amt = phase2 ? amt_cmpl : amt_lo;
      end
      default: begin
        sh_left = 1'b0;
        sh_amt  = '0;
      end
    endcase
  end

  tbm_shifter #(.W(W)) shift_i (
    .data_i (opa),
    .amt_i  (sh_amt),
    .left_i (sh_left),
    .fill_i (1'b0),
    .data_o (sh_out)
  );

  tbm_bwlogic #(.W(W)) bw_i (
    .a_i        (opa),
    .b_i        (opb),
    .invert_b_i (phase2),
    .y_o        (bw_out)
  );

  // first half: partial value for the stage register
  always_comb begin
    unique case (op_cur)
      OP_CMIX:                        stage_d = bw_out;
      OP_CMOV:                        stage_d = opa;
      OP_FSL, OP_FSR, OP_ROL, OP_ROR: stage_d = sh_out;
      default:                        stage_d = '0;
    endcase
  end

  // second half: merge stage register with the switched operand
  always_comb begin
    unique case (op_cur)
      OP_CMIX: merged = stage_q | bw_out;
      OP_CMOV: merged = (opb != '0) ? stage_q : opa;
      OP_ROL, OP_ROR: merged = stage_q | sh_out;
      OP_FSL, OP_FSR: begin
        if (amt_lo == '0) merged = amt_hi ? opa : stage_q;
        else              merged = stage_q | sh_out;
      end
      default: merged = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      result_q <= '0;
    end else begin
      if (accept) stage_q  <= stage_d;
      if (phase2) result_q <= merged;
    end
  end

  assign busy_o   = phase2;
  assign result_o = result_q;
endmodule

// File: rtl/tbm_unit_checker.sv
module tbm_unit_checker #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] rs1_i,
  input logic [W-1:0] rs2_i,
  input logic [W-1:0] rs3_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  import tbm_pkg::*;

  logic [2:0]   cap_op;
  logic [W-1:0] cap_a, cap_b, cap_c;
  logic [AW-1:0] cap_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_op <= '0;
      cap_a  <= '0;
      cap_b  <= '0;
      cap_c  <= '0;
    end else if (start_i && !busy_o) begin
      cap_op <= op_i;
      cap_a  <= rs1_i;
      cap_b  <= rs2_i;
      cap_c  <= rs3_i;
    end
  end

  assign cap_s = cap_b[AW-1:0];

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  p_busy_then_done_r2: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (done_o && !busy_o));
  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_ignore_busy_start_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> !busy_o);
  p_result_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> done_o);
  p_cmov_pick_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && cap_op == OP_CMOV) |-> result_o == ((cap_b != '0) ? cap_a : cap_c));
  p_cmix_merge_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && cap_op == OP_CMIX) |-> result_o == ((cap_a & cap_b) | (cap_c & ~cap_b)));
  p_ror_value_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && cap_op == OP_ROR) |-> result_o == ((cap_a >> cap_s) | (cap_a << (W - int'(cap_s)))));
  p_rol_value_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && cap_op == OP_ROL) |-> result_o == ((cap_a << cap_s) | (cap_a >> (W - int'(cap_s)))));
  p_unused_code_r11: assert property (@(posedge clk) disable iff (rst)
    (done_o && cap_op > OP_ROR) |-> result_o == '0);
endmodule

bind ternary_bitmanip_unit tbm_unit_checker #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .op_i     (op_i),
  .rs1_i    (rs1_i),
  .rs2_i    (rs2_i),
  .rs3_i    (rs3_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/ternary_bitmanip_unit_tb_top.sv
`timescale 1ns/1ps
module ternary_bitmanip_unit_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [2:0]   op = '0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit run_chk = 1'b0;
  logic [31:0] seed = 32'h1357_9bdf;

  always #2 clk = ~clk;

  ternary_bitmanip_unit dut_i (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op),
    .rs1_i(a), .rs2_i(b), .rs3_i(c),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic logic [W-1:0] ref_fn(input logic [2:0] o, input logic [W-1:0] x,
                                          input logic [W-1:0] y, input logic [W-1:0] z);
    logic [63:0] cat;
    int s;
    case (o)
      3'd0: return (x & y) | (z & ~y);
      3'd1: return (y != 0) ? x : z;
      3'd2: begin
        cat = {x, z}; s = int'(y[5:0]);
        cat = (cat << s) | (cat >> (64 - s));
        return cat[63:32];
      end
      3'd3: begin
        cat = {z, x}; s = int'(y[5:0]);
        cat = (cat >> s) | (cat << (64 - s));
        return cat[31:0];
      end
      3'd4: begin s = int'(y[4:0]); return (x << s) | (x >> (32 - s)); end
      3'd5: begin s = int'(y[4:0]); return (x >> s) | (x << (32 - s)); end
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R6";
      3'd1: return "R5";
      3'd2: return "R9";
      3'd3: return "R8";
      3'd4, 3'd5: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: which starts are taken, when results appear
  logic         m_busy, m_done;
  logic [W-1:0] m_res, m_a, m_b, m_c;
  logic [2:0]   m_op;
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_res <= 0; m_op <= 0;
      m_a <= 0; m_b <= 0; m_c <= 0;
    end else begin
      m_done <= m_busy;
      if (m_busy) begin
        m_res  <= ref_fn(m_op, m_a, m_b, m_c);
        m_busy <= 0;
      end else if (start) begin
        m_busy <= 1; m_op <= op; m_a <= a; m_b <= b; m_c <= c;
      end
    end
  end

  always @(negedge clk) begin
    if (run_chk) begin
      check("R2 busy", W'(busy), W'(m_busy));
      check("R2 done", W'(done), W'(m_done));
      check(m_done ? req_of(m_op) : "R4", result, m_res);
    end
  end

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  // start in this negedge, hold operands through the busy cycle;
  // poke raises start with another code during busy (must be ignored)
  task automatic run(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                     input logic [W-1:0] z, input bit poke);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y; c = z;
    @(negedge clk);
    start = poke;
    if (poke) op = o + 3'd3;
  endtask

  task automatic idle_and_check(input string req, input logic [W-1:0] exp);
    @(negedge clk);
    start = 1'b0;
    check(req, result, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", W'(busy), '0);
    check("R1 done in reset", W'(done), '0);
    check("R1 result in reset", result, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", W'(busy), '0);
    check("R1 result after reset", result, '0);
    run_chk = 1'b1;

    // directed corner cases (checked at the done cycle)
    run(3'd1, 32'hAAAA_0001, 32'h0, 32'h5555_0002, 0);
    idle_and_check("R5 cmov zero selector", 32'h5555_0002);
    run(3'd1, 32'hAAAA_0001, 32'h8000_0000, 32'h5555_0002, 0);
    idle_and_check("R5 cmov nonzero selector", 32'hAAAA_0001);
    run(3'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h1234_5678, 0);
    idle_and_check("R6 cmix", 32'hF034_F078);
    run(3'd5, 32'h8000_0001, 32'd33, 32'h0, 0);
    idle_and_check("R7 ror amount mod 32", 32'hC000_0000);
    run(3'd4, 32'h8000_0001, 32'd0, 32'h0, 0);
    idle_and_check("R7 rol zero amount", 32'h8000_0001);
    run(3'd3, 32'h1234_5678, 32'd8, 32'h9ABC_DEF0, 0);
    idle_and_check("R8 fsr by 8", 32'hF012_3456);
    run(3'd3, 32'h1234_5678, 32'd40, 32'h9ABC_DEF0, 0);
    idle_and_check("R8 fsr by 40", 32'h789A_BCDE);
    run(3'd2, 32'h1234_5678, 32'd4, 32'h9ABC_DEF0, 0);
    idle_and_check("R9 fsl by 4", 32'h2345_6789);
    run(3'd2, 32'h1234_5678, 32'd36, 32'h9ABC_DEF0, 0);
    idle_and_check("R9 fsl by 36", 32'hABCD_EF01);
    run(3'd3, 32'h1111_2222, 32'd32, 32'h3333_4444, 0);
    idle_and_check("R10 fsr amount 32", 32'h3333_4444);
    run(3'd3, 32'h1111_2222, 32'd64, 32'h3333_4444, 0);
    idle_and_check("R10 fsr amount 64 wraps to 0", 32'h1111_2222);
    run(3'd2, 32'h1111_2222, 32'd32, 32'h3333_4444, 0);
    idle_and_check("R10 fsl amount 32", 32'h3333_4444);
    run(3'd2, 32'h1111_2222, 32'd0, 32'h3333_4444, 0);
    idle_and_check("R10 fsl amount 0", 32'h1111_2222);
    run(3'd6, 32'hFFFF_FFFF, 32'd5, 32'hFFFF_FFFF, 0);
    idle_and_check("R11 unused code", 32'h0);

    // start during busy must be dropped
    run(3'd5, 32'h0000_00F0, 32'd4, 32'h0, 1);
    @(negedge clk);
    start = 1'b0;
    check("R3 busy not extended", W'(busy), '0);
    check("R3 running op result kept", result, 32'h0000_000F);
    @(negedge clk);
    check("R3 no second completion", W'(done), '0);

    // random traffic, back to back or with gaps, with pokes
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] x, y, z;
      seed = rnd(seed); x = seed;
      seed = rnd(seed); y = (seed[31:29] == 3'd0) ? '0 : (seed[28] ? {26'd0, seed[5:0]} : seed);
      seed = rnd(seed); z = seed;
      run(seed[2:0], x, y, z, seed[7]);
      if (seed[9]) begin
        @(negedge clk);
        start = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule